// File: doc/BRIEF.md
# Interlaced Video Sync Generator

This block produces the raster timing for a 525-line, two-field interlaced video format from a pixel-rate clock. A pixel counter walks each 780-clock line and a line counter walks the 525-line frame. Every output is decoded from the position of these two counters: horizontal drive, vertical drive, composite sync, composite blanking, the field flag, and an optional pulse at twice the line rate. All sync and drive outputs are active-low and come straight from flip-flops, so they carry no decode glitches.

Composite sync is built in whole pixel clocks. Around the start of each field there are three groups of half-line-spaced pulses: narrow equalising pulses, then broad serrated pulses, then narrow equalising pulses again. The second field begins in the middle of a line, so its vertical drive, its sync pattern and its field flag all start half a line later than the line edge.

Each counter has a synchronous load input. An external reset or genlock controller uses these to re-phase the raster to an outside reference, either the horizontal position alone or the line as well.

Top module: `interlace_sync_gen`

## Requirements
- R1: The pixel counter runs from 0 to LINE_CLKS-1 (default 780) and then wraps. The line counter advances on each wrap, runs from 0 to FRAME_LINES-1 (default 525) and then wraps. So the horizontal drive period is LINE_CLKS clocks and the field flag period is LINE_CLKS*FRAME_LINES clocks.
- R2: hd_n is low while the pixel position is below HDRV_W (default 78) and high for the rest of the line.
- R3: Outside the vertical sync interval, csync_n is low while the pixel position is below HSYNC_W (default 60).
- R4: Half-line index = 2*line + (pixel >= LINE_CLKS/2), and the field-relative index fh subtracts FRAME_LINES in the second field. In the equalising groups (fh < EQ_HALVES, or 2*EQ_HALVES <= fh < 3*EQ_HALVES, default EQ_HALVES = 6), csync_n is low for the first EQ_W (default 30) clocks of each half line.
- R5: In the broad group (EQ_HALVES <= fh < 2*EQ_HALVES), csync_n is low for the first SERR_W (default 330) clocks of each half line.
- R6: vd_n is low while fh < 2*VDRV_LINES (default 9 lines). In the second field this begins at the midpoint of line (FRAME_LINES-1)/2.
- R7: field is 0 while the half-line index is below FRAME_LINES and 1 from there to the end of the frame.
- R8: cblank_n is low when the pixel position is at or above LINE_CLKS-HFP_W, when it is below HBLK_W-HFP_W (HBLK_W = 132, HFP_W = 18 by default), or when fh < 2*VBLK_LINES (default 20 lines).
- R9: When dbl_en is high, dbl_n is low for the first HSYNC_W clocks of each half line. When dbl_en is low, dbl_n is held high.
- R10: A pix_load pulse sets the pixel counter to pix_load_val on the next edge, and the line counter does not advance in that cycle. A line_load pulse sets the line counter to line_load_val, and it takes priority over the end-of-line advance.
- R11: Every output is registered and lags the counter state by one clock. While rst_n is low, all active-low outputs read high and field reads 0. The first decoded cycle after reset is pixel 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbl_en | input | 1 | Enables the twice-line-rate output |
| pix_load | input | 1 | Synchronous load strobe for the pixel counter |
| pix_load_val | input | PIX_W | Pixel counter load value |
| line_load | input | 1 | Synchronous load strobe for the line counter |
| line_load_val | input | LINE_W | Line counter load value |
| hd_n | output | 1 | Horizontal drive, active low |
| vd_n | output | 1 | Vertical drive, active low |
| csync_n | output | 1 | Composite sync, active low |
| cblank_n | output | 1 | Composite blanking, active low |
| field | output | 1 | Field flag: 0 in the first field, 1 in the second |
| dbl_n | output | 1 | Twice-line-rate pulse, active low |

## Verification
A wrong pixel count shows up within one line as a shifted or stretched hd_n, csync_n or cblank_n edge. A wrong line count or half-line split shows up only near the vertical interval. There it appears as an equalising pulse where a broad pulse belongs, as a vd_n or field edge on the wrong half line, or as a second field that starts on the line edge instead of mid-line. The bench therefore compares every output in every cycle against an arithmetic model. It covers several full frames of a scaled-down raster, the start of both fields of the full-size raster, and counter loads placed close to the wrap points.

// File: rtl/interlace_sync_gen.sv
module interlace_sync_gen #(
  parameter int LINE_CLKS   = 780,
  parameter int FRAME_LINES = 525,
  parameter int HDRV_W      = 78,
  parameter int HSYNC_W     = 60,
  parameter int HBLK_W      = 132,
  parameter int HFP_W       = 18,
  parameter int EQ_W        = 30,
  parameter int SERR_W      = 330,
  parameter int EQ_HALVES   = 6,
  parameter int VDRV_LINES  = 9,
  parameter int VBLK_LINES  = 20,
  localparam int PIX_W  = $clog2(LINE_CLKS),
  localparam int LINE_W = $clog2(FRAME_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbl_en,
  input  logic              pix_load,
  input  logic [PIX_W-1:0]  pix_load_val,
  input  logic              line_load,
  input  logic [LINE_W-1:0] line_load_val,
  output logic              hd_n,
  output logic              vd_n,
  output logic              csync_n,
  output logic              cblank_n,
  output logic              field,
  output logic              dbl_n
);
  localparam int HL_W = LINE_W + 1;

  localparam logic [PIX_W-1:0]  LAST_P   = PIX_W'(LINE_CLKS - 1);
  localparam logic [PIX_W-1:0]  HALF_P   = PIX_W'(LINE_CLKS / 2);
  localparam logic [PIX_W-1:0]  HDRV_P   = PIX_W'(HDRV_W);
  localparam logic [PIX_W-1:0]  HSYNC_P  = PIX_W'(HSYNC_W);
  localparam logic [PIX_W-1:0]  EQW_P    = PIX_W'(EQ_W);
  localparam logic [PIX_W-1:0]  SERR_P   = PIX_W'(SERR_W);
  localparam logic [PIX_W-1:0]  FP_P     = PIX_W'(LINE_CLKS - HFP_W);
  localparam logic [PIX_W-1:0]  BP_P     = PIX_W'(HBLK_W - HFP_W);
  localparam logic [LINE_W-1:0] LAST_L   = LINE_W'(FRAME_LINES - 1);
  localparam logic [HL_W-1:0]   FRAME_H  = HL_W'(FRAME_LINES);
  localparam logic [HL_W-1:0]   EQ1_H    = HL_W'(EQ_HALVES);
  localparam logic [HL_W-1:0]   EQ2_H    = HL_W'(2 * EQ_HALVES);
  localparam logic [HL_W-1:0]   EQ3_H    = HL_W'(3 * EQ_HALVES);
  localparam logic [HL_W-1:0]   VDRV_H   = HL_W'(2 * VDRV_LINES);
  localparam logic [HL_W-1:0]   VBLK_H   = HL_W'(2 * VBLK_LINES);

  logic [PIX_W-1:0]  pix;
  logic [LINE_W-1:0] line;
  logic              ld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix  <= '0;
      line <= '0;
    end else begin
      if (pix_load)           pix <= pix_load_val;
      else if (pix == LAST_P) pix <= '0;
      else                    pix <= pix + 1'b1;
      if (line_load)
        line <= line_load_val;
      else if (!pix_load && pix == LAST_P)
        line <= (line == LAST_L) ? '0 : line + 1'b1;
    end
  end

  wire              second = pix >= HALF_P;
  wire [HL_W-1:0]   hl     = {line, second};
  wire              fld2   = hl >= FRAME_H;
  wire [HL_W-1:0]   fh     = fld2 ? hl - FRAME_H : hl;
  wire [PIX_W-1:0]  hp     = second ? pix - HALF_P : pix;

  wire eq_zone    = (fh < EQ1_H) || (fh >= EQ2_H && fh < EQ3_H);
  wire broad_zone = (fh >= EQ1_H) && (fh < EQ2_H);
  wire cs_low     = eq_zone ? (hp < EQW_P) : broad_zone ? (hp < SERR_P) : (pix < HSYNC_P);
  wire bl_low     = (pix >= FP_P) || (pix < BP_P) || (fh < VBLK_H);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd_n     <= 1'b1;
      vd_n     <= 1'b1;
      csync_n  <= 1'b1;
      cblank_n <= 1'b1;
      field    <= 1'b0;
      dbl_n    <= 1'b1;
      ld_q     <= 1'b0;
    end else begin
      hd_n     <= !(pix < HDRV_P);
      vd_n     <= !(fh < VDRV_H);
      csync_n  <= !cs_low;
      cblank_n <= !bl_low;
      field    <= fld2;
      dbl_n    <= !(dbl_en && hp < HSYNC_P);
      ld_q     <= pix_load || line_load;
    end
  end

  // R2
  hd_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n) !hd_n |-> !cblank_n);
  // R8
  sync_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n) !csync_n |-> !cblank_n);
  // R6
  vd_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n) !vd_n |-> !cblank_n);
  // R7
  field_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(field) && !ld_q) |-> $fell(vd_n));
  // R9
  dbl_off_chk: assert property (@(posedge clk) disable iff (!rst_n) $past(!dbl_en) |-> dbl_n);
endmodule

// File: tb/interlace_sync_gen_bench.sv
module interlace_sync_gen_bench;
  typedef struct {
    int line, frame, hdrv, hsync, hblk, hfp, eqw, serr, eqh, vdrv, vblk;
  } cfg_t;

  localparam cfg_t CA = '{40, 21, 5, 4, 9, 2, 2, 16, 2, 3, 5};
  localparam cfg_t CB = '{780, 525, 78, 60, 132, 18, 30, 330, 6, 9, 20};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  logic       en_a = 1'b1, pl_a = 1'b0, ll_a = 1'b0;
  logic [5:0] pv_a = '0;
  logic [4:0] lv_a = '0;
  logic [5:0] out_a;
  logic       en_b = 1'b1, pl_b = 1'b0, ll_b = 1'b0;
  logic [9:0] pv_b = '0;
  logic [9:0] lv_b = '0;
  logic [5:0] out_b;

  interlace_sync_gen #(.LINE_CLKS(40), .FRAME_LINES(21), .HDRV_W(5), .HSYNC_W(4),
    .HBLK_W(9), .HFP_W(2), .EQ_W(2), .SERR_W(16), .EQ_HALVES(2), .VDRV_LINES(3),
    .VBLK_LINES(5)) u_interlace_sync_gen (
    .clk(clk), .rst_n(rst_n), .dbl_en(en_a), .pix_load(pl_a), .pix_load_val(pv_a),
    .line_load(ll_a), .line_load_val(lv_a), .hd_n(out_a[5]), .vd_n(out_a[4]),
    .csync_n(out_a[3]), .cblank_n(out_a[2]), .field(out_a[1]), .dbl_n(out_a[0]));

  interlace_sync_gen u_full (
    .clk(clk), .rst_n(rst_n), .dbl_en(en_b), .pix_load(pl_b), .pix_load_val(pv_b),
    .line_load(ll_b), .line_load_val(lv_b), .hd_n(out_b[5]), .vd_n(out_b[4]),
    .csync_n(out_b[3]), .cblank_n(out_b[2]), .field(out_b[1]), .dbl_n(out_b[0]));

  function automatic int fh_of(cfg_t c, int p, int l);
    int h = 2 * l + ((p >= c.line / 2) ? 1 : 0);
    return (h >= c.frame) ? h - c.frame : h;
  endfunction

  function automatic logic [5:0] model(cfg_t c, int p, int l, logic en);
    int half = c.line / 2;
    int h  = 2 * l + ((p >= half) ? 1 : 0);
    int fh = fh_of(c, p, l);
    int hp = (p >= half) ? p - half : p;
    logic cs;
    if (fh < c.eqh || (fh >= 2 * c.eqh && fh < 3 * c.eqh)) cs = (hp < c.eqw);
    else if (fh < 2 * c.eqh) cs = (hp < c.serr);
    else cs = (p < c.hsync);
    return {!(p < c.hdrv), !(fh < 2 * c.vdrv), !cs,
            !(p >= c.line - c.hfp || p < c.hblk - c.hfp || fh < 2 * c.vblk),
            logic'(h >= c.frame), !(en && hp < c.hsync)};
  endfunction

  function automatic string cs_tag(cfg_t c, int p, int l);
    int fh = fh_of(c, p, l);
    if (fh < c.eqh || (fh >= 2 * c.eqh && fh < 3 * c.eqh)) return "R4";
    if (fh < 2 * c.eqh) return "R5";
    return "R3";
  endfunction

  int pa = 0, la = 0, pb = 0, lb = 0;
  logic [5:0] exp_a = 6'b111101, exp_b = 6'b111101;
  string tg_a = "R11", tg_b = "R11";

  always @(posedge clk) begin
    if (!rst_n) begin
      pa = 0; la = 0; pb = 0; lb = 0;
      exp_a <= 6'b111101; exp_b <= 6'b111101;
      tg_a <= "R11"; tg_b <= "R11";
    end else begin
      exp_a <= model(CA, pa, la, en_a);
      tg_a  <= cs_tag(CA, pa, la);
      if (ll_a) la = int'(lv_a);
      else if (!pl_a && pa == CA.line - 1) la = (la == CA.frame - 1) ? 0 : la + 1;
      pa = pl_a ? int'(pv_a) : ((pa == CA.line - 1) ? 0 : pa + 1);
      exp_b <= model(CB, pb, lb, en_b);
      tg_b  <= cs_tag(CB, pb, lb);
      if (ll_b) lb = int'(lv_b);
      else if (!pl_b && pb == CB.line - 1) lb = (lb == CB.frame - 1) ? 0 : lb + 1;
      pb = pl_b ? int'(pv_b) : ((pb == CB.line - 1) ? 0 : pb + 1);
    end
  end

  task automatic cmp(string inst, logic [5:0] act, logic [5:0] exp, string cstag, bit in_rst);
    string names[6] = '{"dbl_n", "field", "cblank_n", "csync_n", "vd_n", "hd_n"};
    string tags[6]  = '{"R9", "R7", "R8", "", "R6", "R2"};
    for (int i = 0; i < 6; i++) begin
      string t = in_rst ? "R11" : (i == 3 ? cstag : tags[i]);
      tests++;
      if (act[i] !== exp[i]) begin
        fails++;
        $display("FAIL %s %s %s: actual %b expected %b at %0t", t, inst, names[i], act[i], exp[i], $time);
      end
    end
  endtask

  always @(negedge clk) begin
    cmp("small", out_a, exp_a, tg_a, !rst_n);
    cmp("full", out_b, exp_b, tg_b, !rst_n);
  end

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 line period on the small raster
    n = 0;
    do @(negedge clk); while (out_a[5]);
    do begin @(negedge clk); n++; end while (!out_a[5]);
    do begin @(negedge clk); n++; end while (out_a[5]);
    check("R1 line period", n, CA.line);

    // R1 frame period via field rising edges
    do @(negedge clk); while (out_a[1]);
    do @(negedge clk); while (!out_a[1]);
    n = 0;
    do begin @(negedge clk); n++; end while (out_a[1]);
    do begin @(negedge clk); n++; end while (!out_a[1]);
    check("R1 frame period", n, CA.line * CA.frame);

    // R9 toggle the doubled output enable for a frame
    en_a = 1'b0; en_b = 1'b0;
    repeat (CA.line * CA.frame) @(negedge clk);
    en_a = 1'b1; en_b = 1'b1;
    repeat (CA.line * CA.frame) @(negedge clk);

    // R10 pixel load near line end
    pl_a = 1'b1; pv_a = 6'(CA.line - 3);
    @(negedge clk);
    pl_a = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 hd_n before wrap after load", int'(out_a[5]), 1);
    repeat (2) @(negedge clk);
    check("R10 hd_n at wrap after load", int'(out_a[5]), 0);

    // R10 line load to the last line, mid-line
    ll_a = 1'b1; lv_a = 5'(CA.frame - 1); pl_a = 1'b1; pv_a = 6'(10);
    @(negedge clk);
    ll_a = 1'b0; pl_a = 1'b0;
    @(negedge clk);
    check("R10 field after line load", int'(out_a[1]), 1);
    repeat (CA.line * CA.frame) @(negedge clk);

    // R10 simultaneous pixel load at line end holds the line
    repeat (CA.line - 1) @(negedge clk);
    pl_a = 1'b1; pv_a = 6'(CA.line - 1);
    @(negedge clk);
    pl_a = 1'b0;
    repeat (3 * CA.line) @(negedge clk);

    // full raster: first 40 lines of the first field
    wait (pb == 0 && lb == 40);
    @(negedge clk);

    // R6 R7 jump just before the second field start
    ll_b = 1'b1; lv_b = 10'd259; pl_b = 1'b1; pv_b = 10'd700;
    @(negedge clk);
    ll_b = 1'b0; pl_b = 1'b0;
    repeat (15 * CB.line) @(negedge clk);

    // R7 wrap from the last line into the first field
    ll_b = 1'b1; lv_b = 10'd524; pl_b = 1'b1; pv_b = 10'd770;
    @(negedge clk);
    ll_b = 1'b0; pl_b = 1'b0;
    @(negedge clk);
    check("R7 field in last line", int'(out_b[1]), 1);
    repeat (10) @(negedge clk);
    check("R7 field after frame wrap", int'(out_b[1]), 0);
    check("R6 vd_n after frame wrap", int'(out_b[4]), 0);
    repeat (30 * CB.line) @(negedge clk);

    finish_run();
  end
endmodule